// File: doc/BRIEF.md
# Headset Jack Detection Controller

This controller sits behind two comparator outputs on a headset jack. One reports that a plug is seated and the other reports that the headset button is closed. Each signal passes through a two-flop synchronizer and then a debounce counter. The counter advances only on a 1 ms tick, so the plug input and the button input each settle through their own programmable window before the controller accepts a new level.

Software sees the settled levels as live status bits. Events are kept apart in latched flags that a read of the flag register clears. Each kind of event can be steered to either or both of two interrupt lines, so software does not have to poll. When a plug is accepted, the controller captures a 2-bit headset-kind code supplied by the analog front end. It holds that code until the plug is removed. While the enable bit is clear, the whole detection path is held idle.

All control and status sit in four byte-wide registers on a simple read/write port. Read data is combinational from the address, and a write takes effect at the clock edge where `reg_wr` is high.

Top module: `jack_sense_ctrl`

## Requirements
- R1: While the enable bit (register 0, bit 0) is clear, the status register (2), the flag register (3) and both interrupt outputs read zero. A flag that was set becomes zero one cycle after enable is cleared.
- R2: The plug debounce select (register 0, bits 3:1) gives a window of 32, 64, 128, 256 or 512 ticks for codes 0 to 4. Codes 5 to 7 give 512 ticks. The live plug bit follows a new raw level only after the raw input has held that level for the full window, plus two cycles of synchronizer latency. The counter advances only in cycles where `tick_ms` is high.
- R3: The button debounce select (register 0, bits 5:4) gives a window of 8, 16 or 32 ticks for codes 0 to 2. Code 3 gives 32 ticks. Timing is otherwise as in R2.
- R4: The status register shows the debounced plug level in bit 0 and the debounced button level in bit 1.
- R5: Flag bit 0 (register 3) sets on every accepted plug change, whether insertion or removal. Flag bit 1 sets on an accepted button press and does not set on a release.
- R6: Reading register 3 with `reg_rd` returns the flags and clears them at that clock edge. If an event is accepted at the same edge as the read, its flag stays set.
- R7: Register 1 routes the flags: bit 0 sends the plug flag to `irq_a`, bit 1 sends it to `irq_b`, bit 2 sends the button flag to `irq_a`, and bit 3 sends it to `irq_b`. Each interrupt is the OR of its routed flags.
- R8: When an insertion is accepted, `kind_code` is captured into status bits 3:2. These bits read zero while no plug is accepted.
- R9: If the raw input returns to the settled level before the window ends, the counter restarts. The live bit does not change and no flag is set.
- R10: While no plug is accepted, the button is held released and no button flag is set. When a plug removal is accepted, the button status is forced to released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle pulse marking each millisecond |
| plug_raw | input | 1 | Asynchronous plug-present comparator output |
| button_raw | input | 1 | Asynchronous button-closed comparator output |
| kind_code | input | 2 | Headset kind code from the analog classifier |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of register 3 clears the flags |
| reg_addr | input | 2 | Register address (0 control, 1 routing, 2 status, 3 flags) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_a | output | 1 | First interrupt line |
| irq_b | output | 1 | Second interrupt line |

## Verification
The hardest case to reach is a flag read that falls on the exact edge where a new event is accepted. To create it, the stimulus counts from the raw button edge through the two synchronizer cycles and the full debounce window. It asserts the read strobe in the final cycle, then checks that the button flag is still set afterwards. The same cycle counting checks each debounce length on both sides: the live bit must still be low one cycle before the window ends and high on the cycle it ends. It also forces a removal while the button is still held, to show the button status is forced to released.

// File: rtl/jsc_pkg.sv
`timescale 1ns/1ps
package jsc_pkg;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_ROUTE  = 2'd1;
    localparam logic [1:0] ADDR_STATUS = 2'd2;
    localparam logic [1:0] ADDR_FLAGS  = 2'd3;

    typedef struct packed {
        logic [1:0] btn_sel;
        logic [2:0] plug_sel;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic btn_b;
        logic btn_a;
        logic plug_b;
        logic plug_a;
    } route_t;

    typedef struct packed {
        logic btn;
        logic plug;
    } flags_t;

    typedef struct packed {
        ctrl_t      ctrl;
        route_t     route;
        flags_t     flags;
        logic [1:0] kind;
    } state_t;

endpackage

// File: rtl/jsc_sync.sv
`timescale 1ns/1ps
module jsc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/jsc_debounce.sv
`timescale 1ns/1ps
module jsc_debounce #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic          din,
    input  logic [CW-1:0] limit,
    output logic          stable,
    output logic          evt_rise,
    output logic          evt_fall
);
    logic          stable_d, stable_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          expire;

    assign expire = !clr && tick && (din != stable_q) && (cnt_q >= limit - 1'b1);

    always_comb begin
        stable_d = stable_q;
        cnt_d    = cnt_q;
        if (clr) begin
            stable_d = 1'b0;
            cnt_d    = '0;
        end else if (din == stable_q) begin
            cnt_d = '0;
        end else if (tick) begin
            if (expire) begin
                stable_d = din;
                cnt_d    = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stable_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            stable_q <= stable_d;
            cnt_q    <= cnt_d;
        end
    end

    assign stable   = stable_q;
    assign evt_rise = expire && din;
    assign evt_fall = expire && !din;

    AST_WINDOW_ELAPSED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(stable_q) && !$past(clr)) |-> ($past(tick) && ($past(cnt_q) >= $past(limit) - 1'b1))); // R9
endmodule

// File: rtl/jack_sense_ctrl.sv
`timescale 1ns/1ps
module jack_sense_ctrl
    import jsc_pkg::*;
#(
    parameter int PLUG_BASE_MS = 32,
    parameter int PLUG_STEPS   = 5,
    parameter int BTN_BASE_MS  = 8,
    parameter int BTN_STEPS    = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       plug_raw,
    input  logic       button_raw,
    input  logic [1:0] kind_code,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_a,
    output logic       irq_b
);
    localparam int PLUG_MAX = PLUG_BASE_MS << (PLUG_STEPS - 1);
    localparam int CW       = $clog2(PLUG_MAX + 1);

    state_t st_d, st_q;

    logic [1:0]    sync_out;
    logic          plug_s, btn_s;
    logic          plug_stable, btn_stable;
    logic          plug_rise, plug_fall, btn_rise, btn_fall;
    logic [CW-1:0] plug_lim, btn_lim;
    logic          rd_flags;

    function automatic logic [CW-1:0] window(input int base, input int steps, input int sel);
        int sh;
        sh = (sel >= steps) ? steps - 1 : sel;
        return CW'(base) << sh;
    endfunction

    jsc_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({button_raw, plug_raw}),
        .dout  (sync_out)
    );
    assign plug_s = sync_out[0];
    assign btn_s  = sync_out[1];

    assign plug_lim = window(PLUG_BASE_MS, PLUG_STEPS, int'(st_q.ctrl.plug_sel));
    assign btn_lim  = window(BTN_BASE_MS, BTN_STEPS, int'(st_q.ctrl.btn_sel));

    jsc_debounce #(.CW(CW)) i_plug_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!st_q.ctrl.en),
        .tick     (tick_ms),
        .din      (plug_s),
        .limit    (plug_lim),
        .stable   (plug_stable),
        .evt_rise (plug_rise),
        .evt_fall (plug_fall)
    );

    jsc_debounce #(.CW(CW)) i_btn_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!st_q.ctrl.en || !plug_stable),
        .tick     (tick_ms),
        .din      (btn_s),
        .limit    (btn_lim),
        .stable   (btn_stable),
        .evt_rise (btn_rise),
        .evt_fall (btn_fall)
    );

    assign rd_flags = reg_rd && (reg_addr == ADDR_FLAGS);

    always_comb begin
        st_d = st_q;
        if (reg_wr && reg_addr == ADDR_CTRL)  st_d.ctrl  = ctrl_t'(reg_wdata[5:0]);
        if (reg_wr && reg_addr == ADDR_ROUTE) st_d.route = route_t'(reg_wdata[3:0]);

        if (rd_flags)               st_d.flags      = '0;
        if (plug_rise || plug_fall) st_d.flags.plug = 1'b1;
        if (btn_rise)               st_d.flags.btn  = 1'b1;

        if (plug_rise)              st_d.kind = kind_code;
        if (plug_fall)              st_d.kind = 2'b00;

        if (!st_q.ctrl.en) begin
            st_d.flags = '0;
            st_d.kind  = 2'b00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL:   reg_rdata = {2'b00, st_q.ctrl};
            ADDR_ROUTE:  reg_rdata = {4'b0000, st_q.route};
            ADDR_STATUS: reg_rdata = {4'b0000, st_q.kind, btn_stable, plug_stable};
            default:     reg_rdata = {6'b000000, st_q.flags};
        endcase
    end

    assign irq_a = (st_q.flags.plug && st_q.route.plug_a) || (st_q.flags.btn && st_q.route.btn_a);
    assign irq_b = (st_q.flags.plug && st_q.route.plug_b) || (st_q.flags.btn && st_q.route.btn_b);

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.en |=> (!irq_a && !irq_b && st_q.flags == '0)); // R1
    AST_PLUG_EVENT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (plug_rise || plug_fall) |=> st_q.flags.plug); // R5
    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flags.btn && !rd_flags && st_q.ctrl.en) |=> st_q.flags.btn); // R6
    AST_NO_BUTTON_UNPLUGGED: assert property (@(posedge clk) disable iff (!rst_n)
        !plug_stable |=> !btn_stable); // R10
    AST_BUTTON_NEEDS_PLUG: assert property (@(posedge clk) disable iff (!rst_n)
        btn_rise |-> plug_stable); // R10
endmodule

// File: tb/test_jack_sense_ctrl.sv
`timescale 1ns/1ps
module test_jack_sense_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b1;
    logic       plug_raw = 1'b0;
    logic       button_raw = 1'b0;
    logic [1:0] kind_code = 2'b00;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq_a, irq_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam int PLUG_TAB [8] = '{32, 64, 128, 256, 512, 512, 512, 512};
    localparam int BTN_TAB  [4] = '{8, 16, 32, 32};

    always #4 clk = ~clk;

    jack_sense_ctrl i_jack_sense_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .plug_raw(plug_raw),
        .button_raw(button_raw), .kind_code(kind_code), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_flags(output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 2'd3;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        for (int a = 0; a < 4; a++) begin
            peek(2'(a), v);
            chk(v, 0, "R1 reset register");
        end
        chk({irq_a, irq_b}, 0, "R1 reset irq");

        // R1: disabled, plug held long
        plug_raw = 1'b1;
        cyc(600);
        peek(2'd2, v); chk(v, 0, "R1 status while disabled");
        peek(2'd3, v); chk(v, 0, "R1 flags while disabled");
        chk({irq_a, irq_b}, 0, "R1 irq while disabled");
        plug_raw = 1'b0;
        cyc(5);

        // R2: walk plug debounce table
        for (int code = 0; code < 8; code++) begin
            int n;
            n = PLUG_TAB[code];
            wr(2'd0, {2'b00, 3'(code), 1'b1});
            rd_flags(v);
            @(negedge clk) plug_raw = 1'b1;
            cyc(n + 1);
            peek(2'd2, v); chk(v[0], 0, "R2 plug before window");
            cyc(1);
            peek(2'd2, v); chk(v[0], 1, "R2 plug at window (R4 status)");
            rd_flags(v); chk(v, 8'h01, "R5 insertion flag");
            @(negedge clk) plug_raw = 1'b0;
            cyc(n + 2);
            peek(2'd2, v); chk(v[0], 0, "R2 plug removed at window");
            rd_flags(v); chk(v, 8'h01, "R5 removal flag");
        end

        // R2 tick gating, R8 kind capture
        wr(2'd0, 8'h01);
        kind_code = 2'b10;
        tick_ms = 1'b0;
        @(negedge clk) plug_raw = 1'b1;
        cyc(100);
        peek(2'd2, v); chk(v, 0, "R2 no count without tick");
        tick_ms = 1'b1;
        cyc(31);
        peek(2'd2, v); chk(v[0], 0, "R2 tick window not yet");
        cyc(1);
        peek(2'd2, v); chk(v, 8'h09, "R8 kind captured on insertion");
        rd_flags(v);
        wr(2'd1, 8'h01);

        // R3: walk button debounce table with plug inserted
        for (int code = 0; code < 4; code++) begin
            int n;
            n = BTN_TAB[code];
            wr(2'd0, {2'(code), 3'b000, 1'b1});
            @(negedge clk) button_raw = 1'b1;
            cyc(n + 1);
            peek(2'd2, v); chk(v[1], 0, "R3 button before window");
            cyc(1);
            peek(2'd2, v); chk(v[1], 1, "R3 button at window (R4 status)");
            chk({irq_a, irq_b}, 0, "R7 unrouted button flag");
            rd_flags(v); chk(v, 8'h02, "R5 press flag");
            @(negedge clk) button_raw = 1'b0;
            cyc(n + 2);
            peek(2'd2, v); chk(v[1], 0, "R3 button released");
            rd_flags(v); chk(v, 8'h00, "R5 release sets no flag");
        end

        // R7: routing, plug -> B, button -> A
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h06);
        @(negedge clk) plug_raw = 1'b0;
        cyc(40);
        chk({irq_a, irq_b}, 2'b01, "R7 plug to irq_b only");
        peek(2'd2, v); chk(v, 0, "R8 kind cleared on removal");
        rd_flags(v);
        chk({irq_a, irq_b}, 2'b00, "R6 irq drops after read clear");
        wr(2'd1, 8'h0F);
        kind_code = 2'b01;
        @(negedge clk) plug_raw = 1'b1;
        cyc(40);
        chk({irq_a, irq_b}, 2'b11, "R7 plug to both lines");
        peek(2'd2, v); chk(v, 8'h05, "R8 second kind code");
        rd_flags(v);
        peek(2'd3, v); chk(v, 0, "R6 flags cleared by read");

        // R9: short glitch on plug
        @(negedge clk) plug_raw = 1'b0;
        cyc(20);
        plug_raw = 1'b1;
        cyc(60);
        peek(2'd2, v); chk(v[0], 1, "R9 glitch ignored status");
        peek(2'd3, v); chk(v, 0, "R9 glitch sets no flag");

        // R6: event and read at the same edge
        @(negedge clk) button_raw = 1'b1;
        cyc(9);
        reg_rd = 1'b1; reg_addr = 2'd3;
        #1 v = reg_rdata;
        chk(v[1], 0, "R6 flag not yet set before edge");
        @(negedge clk) reg_rd = 1'b0;
        peek(2'd3, v); chk(v[1], 1, "R6 event kept despite read");
        chk(irq_a, 1, "R7 button to irq_a");
        rd_flags(v);

        // R10: removal with button held
        @(negedge clk) plug_raw = 1'b0;
        cyc(40);
        peek(2'd2, v); chk(v, 0, "R10 button forced released on removal");
        rd_flags(v); chk(v, 8'h01, "R10 only plug flag on removal");
        button_raw = 1'b0;
        cyc(20);
        button_raw = 1'b1;
        cyc(60);
        peek(2'd2, v); chk(v[1], 0, "R10 button ignored unplugged");
        peek(2'd3, v); chk(v, 0, "R10 no button flag unplugged");
        button_raw = 1'b0;

        // R1: disable clears pending flags
        @(negedge clk) plug_raw = 1'b1;
        cyc(40);
        peek(2'd3, v); chk(v, 8'h01, "R5 flag pending before disable");
        wr(2'd0, 8'h00);
        cyc(2);
        peek(2'd3, v); chk(v, 0, "R1 flags cleared by disable");
        peek(2'd2, v); chk(v, 0, "R1 status cleared by disable");
        chk({irq_a, irq_b}, 0, "R1 irq cleared by disable");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule